// File: doc/BRIEF.md
# Firmware Hub Bus Host

This block is the master end of a 4-bit multiplexed firmware-hub bus. A client gives it one single-byte read or write request. Each request carries a 4-bit target ID, a 28-bit address and, for writes, a data byte. The host then runs the whole frame on the shared nibble bus. It pulses the frame strobe and sends the cycle-type code, the target ID, the address and the size nibble. For a write it also sends the data byte. It then hands the bus to the target and follows the target's sync nibbles until the transfer ends.

The bus pins are split into an output nibble, an output enable and an input nibble, so the pad ring can build the tri-state. A target may insert any number of wait syncs. A watchdog counter ends the transfer if waiting goes on too long. A sync code the host does not recognise ends the transfer at once. Every transfer ends with a one-clock response that carries read data and a status code.

Top module: `fwh_host`

## Requirements
- R1: While `rst_ni` is low, and from the first clock after it rises until a request is accepted, `req_ready_o`=1, `frame_n_o`=1, `lad_oe_o`=0 and `rsp_valid_o`=0. Asserting reset in the middle of a transfer releases the bus at once.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 from that edge until the response cycle. Requests presented while busy are ignored.
- R3: In the first clock after acceptance, `frame_n_o`=0 and `lad_o` carries 4'b1101 for a read or 4'b1110 for a write. `frame_n_o` is 1 in every other cycle.
- R4: The next clocks drive, in order: the ID nibble, the seven address nibbles from most to least significant, and the size nibble 4'b0000.
- R5: For a write, the two clocks after the size nibble carry `wdata[3:0]` and then `wdata[7:4]`.
- R6: The host then drives 4'b1111 for one clock with `lad_oe_o`=1. It then holds `lad_oe_o`=0 until the transfer ends.
- R7: In the sync phase, 4'b0101 on `lad_i` is a wait and keeps the host waiting. 4'b0000 is ready.
- R8: On a read, the two clocks after the ready sync carry the low and then the high data nibble. The byte is returned on `rsp_rdata_o`.
- R9: After the ready sync (and read data), the host allows two target turnaround clocks. It then gives a response with status 2'b00 and is idle again, with ready high and the bus released.
- R10: A ready sync is accepted after at most WAIT_LIMIT-1 consecutive waits. The WAIT_LIMIT-th consecutive wait ends the transfer, and the next cycle gives a response with status 2'b01.
- R11: Any sync nibble other than 4'b0101 or 4'b0000 ends the transfer, and the next cycle gives a response with status 2'b10. `rsp_rdata_o` is 0 whenever the status is not 2'b00 or the transfer was a write.
- R12: `rsp_valid_o` is high for exactly one clock per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Host idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_id_i | input | 4 | Target ID |
| req_addr_i | input | 28 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-clock response strobe |
| rsp_rdata_o | output | 8 | Read data |
| rsp_status_o | output | 2 | 00 ok, 01 timeout, 10 bad sync |
| frame_n_o | output | 1 | Active-low frame strobe |
| lad_o | output | 4 | Bus nibble driven by the host |
| lad_oe_o | output | 1 | Host bus drive enable |
| lad_i | input | 4 | Bus nibble as seen on the pins |

## Verification
A wrong sequencer state shows up on the nibble bus in the very clock it happens. The result is a misplaced address or data nibble, a strobe outside the code cycle, or the host still driving when the target owns the bus. The bench compares every driven nibble clock by clock. A wait counter that is off by one moves the timeout response by exactly one clock, and a mishandled sync code gives the wrong status in the response cycle. The bench therefore checks the exact response cycle and its contents for every sync pattern.

// File: rtl/fwh_host_pkg.sv
package fwh_host_pkg;
  localparam int unsigned NIB_W        = 4;
  localparam int unsigned ID_W         = 4;
  localparam int unsigned ADDR_W       = 28;
  localparam int unsigned DATA_W       = 8;
  localparam int unsigned ADDR_NIBBLES = ADDR_W / NIB_W;

  localparam logic [NIB_W-1:0] CODE_RD    = 4'b1101;
  localparam logic [NIB_W-1:0] CODE_WR    = 4'b1110;
  localparam logic [NIB_W-1:0] SIZE_BYTE  = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_TAR    = 4'b1111;
  localparam logic [NIB_W-1:0] SYNC_WAIT  = 4'b0101;
  localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CODE, ST_ID, ST_ADDR, ST_SIZE, ST_WDATA,
    ST_HTAR0, ST_HTAR1, ST_SYNC, ST_RDATA, ST_TTAR0, ST_TTAR1
  } state_e;

  typedef enum logic [1:0] {
    RSP_OK      = 2'b00,
    RSP_TIMEOUT = 2'b01,
    RSP_BADSYNC = 2'b10
  } rsp_status_e;
endpackage

// File: rtl/fwh_host_drive.sv
module fwh_host_drive
  import fwh_host_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  state_e            state_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              write_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NIB_W-1:0]  lad_o,
  output logic              lad_oe_o,
  output logic              frame_n_o
);
  localparam int unsigned SLOTS = 2 ** IDX_W;

  logic [NIB_W-1:0] addr_nib [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_nib
    if (g < ADDR_NIBBLES) begin : g_real
      assign addr_nib[g] = addr_i[g*NIB_W +: NIB_W];
    end else begin : g_pad
      assign addr_nib[g] = '0;
    end
  end

  always_comb begin
    frame_n_o = 1'b1;
    lad_oe_o  = 1'b1;
    lad_o     = NIB_TAR;
    unique case (state_i)
      ST_CODE: begin
        frame_n_o = 1'b0;
        lad_o     = write_i ? CODE_WR : CODE_RD;
      end
      ST_ID:    lad_o = id_i;
      ST_ADDR:  lad_o = addr_nib[idx_i];
      ST_SIZE:  lad_o = SIZE_BYTE;
      ST_WDATA: lad_o = idx_i[0] ? wdata_i[2*NIB_W-1:NIB_W] : wdata_i[NIB_W-1:0];
      ST_HTAR0: lad_o = NIB_TAR;
      default:  lad_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fwh_host_wait_timer.sv
module fwh_host_wait_timer #(
  parameter int unsigned WAIT_LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic wait_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = wait_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i || !wait_i)    cnt_q <= '0;
    else if (!expired_o)            cnt_q <= cnt_q + 1'b1;
  end

  AST_WAIT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WAIT_LIMIT)); // R10
endmodule

// File: rtl/fwh_host.sv
module fwh_host
  import fwh_host_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [3:0]  req_id_i,
  input  logic [27:0] req_addr_i,
  input  logic [7:0]  req_wdata_i,
  output logic        rsp_valid_o,
  output logic [7:0]  rsp_rdata_o,
  output logic [1:0]  rsp_status_o,
  output logic        frame_n_o,
  output logic [3:0]  lad_o,
  output logic        lad_oe_o,
  input  logic [3:0]  lad_i
);
  localparam int unsigned IDX_W = $clog2(ADDR_NIBBLES);
  localparam logic [IDX_W-1:0] ADDR_FIRST = IDX_W'(ADDR_NIBBLES - 1);

  state_e            state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wr_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_valid_q;
  rsp_status_e       status_q;
  logic              in_sync, seen_wait, wait_expired;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rdata_q;
  assign rsp_status_o = status_q;
  assign in_sync      = (state_q == ST_SYNC);
  assign seen_wait    = in_sync && (lad_i == SYNC_WAIT);

  fwh_host_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk_i, .rst_ni,
    .clear_i  (!in_sync),
    .wait_i   (seen_wait),
    .expired_o(wait_expired)
  );

  fwh_host_drive #(.IDX_W(IDX_W)) u_drive (
    .state_i  (state_q),
    .idx_i    (idx_q),
    .write_i  (wr_q),
    .id_i     (id_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .lad_o,
    .lad_oe_o,
    .frame_n_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      wr_q        <= 1'b0;
      id_q        <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      status_q    <= RSP_OK;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          id_q    <= req_id_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          rdata_q <= '0;
          state_q <= ST_CODE;
        end
        ST_CODE: state_q <= ST_ID;
        ST_ID: begin
          idx_q   <= ADDR_FIRST;
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (idx_q == '0) state_q <= ST_SIZE;
          else             idx_q   <= idx_q - 1'b1;
        end
        ST_SIZE: begin
          idx_q   <= '0;
          state_q <= wr_q ? ST_WDATA : ST_HTAR0;
        end
        ST_WDATA: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q[0]) state_q <= ST_HTAR0;
        end
        ST_HTAR0: state_q <= ST_HTAR1;
        ST_HTAR1: state_q <= ST_SYNC;
        ST_SYNC: begin
          idx_q <= '0;
          if (lad_i == SYNC_READY) begin
            state_q <= wr_q ? ST_TTAR0 : ST_RDATA;
          end else if (lad_i == SYNC_WAIT) begin
            if (wait_expired) begin
              state_q     <= ST_IDLE;
              rsp_valid_q <= 1'b1;
              status_q    <= RSP_TIMEOUT;
            end
          end else begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            status_q    <= RSP_BADSYNC;
          end
        end
        ST_RDATA: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q[0]) begin
            rdata_q[2*NIB_W-1:NIB_W] <= lad_i;
            state_q <= ST_TTAR0;
          end else begin
            rdata_q[NIB_W-1:0] <= lad_i;
          end
        end
        ST_TTAR0: state_q <= ST_TTAR1;
        ST_TTAR1: begin
          state_q     <= ST_IDLE;
          rsp_valid_q <= 1'b1;
          status_q    <= RSP_OK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_OPENS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!frame_n_o && !req_ready_o)); // R2
  AST_STROBE_WITH_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n_o |-> (lad_oe_o && (lad_o == CODE_RD || lad_o == CODE_WR))); // R3
  AST_HOST_TAR_THEN_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HTAR0) |=> !lad_oe_o); // R6
  AST_NO_DRIVE_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sync |-> !lad_oe_o); // R6
  AST_TIMEOUT_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_expired |=> (rsp_valid_o && rsp_status_o == RSP_TIMEOUT)); // R10
  AST_BADSYNC_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sync && lad_i != SYNC_WAIT && lad_i != SYNC_READY)
      |=> (rsp_valid_o && rsp_status_o == RSP_BADSYNC)); // R11
  AST_RSP_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R12
endmodule

// File: tb/fwh_host_tb_top.sv
module fwh_host_tb_top;
  localparam int unsigned LIMIT = 8;

  typedef struct packed {
    logic        wr;
    logic [3:0]  id;
    logic [27:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [7:0]  waits;
    logic [3:0]  fin;
    logic [1:0]  status;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h3, 28'h1234567, 8'h00, 8'hA5, 8'd2, 4'h0, 2'd0},
    '{1'b1, 4'hA, 28'hFFFFFFF, 8'h3C, 8'h00, 8'd0, 4'h0, 2'd0},
    '{1'b0, 4'h0, 28'h0000000, 8'h00, 8'h0F, 8'd7, 4'h0, 2'd0},
    '{1'b1, 4'h5, 28'h89ABCDE, 8'h77, 8'h00, 8'd8, 4'h0, 2'd1},
    '{1'b0, 4'hF, 28'h0F0F0F0, 8'h00, 8'h99, 8'd1, 4'h9, 2'd2},
    '{1'b1, 4'h6, 28'h7654321, 8'hC3, 8'h00, 8'd3, 4'h0, 2'd0},
    '{1'b0, 4'h1, 28'hA5A5A5A, 8'h00, 8'h12, 8'd0, 4'hF, 2'd2},
    '{1'b0, 4'h2, 28'h1000001, 8'h00, 8'h34, 8'd8, 4'h0, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_id = '0;
  logic [27:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  lad_in = 4'hF;
  logic        req_ready, rsp_valid, frame_n, lad_oe;
  logic [7:0]  rsp_rdata;
  logic [1:0]  rsp_status;
  logic [3:0]  lad_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fwh_host #(.WAIT_LIMIT(LIMIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_id_i(req_id),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_status_o(rsp_status),
    .frame_n_o(frame_n), .lad_o(lad_out), .lad_oe_o(lad_oe), .lad_i(lad_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input vec_t v, input bit hold);
    logic [3:0] exp_nib [12];
    int n;
    logic [7:0] exp_rd;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_id = v.id;
    req_addr = v.addr; req_wdata = v.wdata;
    chk(req_ready, "R2 ready before accept", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    if (hold) begin
      req_write = ~v.wr; req_id = ~v.id; req_addr = ~v.addr; req_wdata = ~v.wdata;
    end else req_valid = 1'b0;
    exp_nib[0] = v.wr ? 4'b1110 : 4'b1101;
    exp_nib[1] = v.id;
    for (int i = 0; i < 7; i++) exp_nib[2+i] = v.addr[(6-i)*4 +: 4];
    exp_nib[9] = 4'b0000;
    exp_nib[10] = v.wdata[3:0];
    exp_nib[11] = v.wdata[7:4];
    n = v.wr ? 12 : 10;
    for (int c = 0; c < n; c++) begin
      if (c > 0) @(negedge clk);
      tag = (c == 0) ? "R3 code" : (c < 10) ? "R4 header" : "R5 wdata";
      chk(lad_oe && lad_out == exp_nib[c], tag, {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, exp_nib[c]});
      chk(frame_n == (c != 0), "R3 strobe", {31'd0, frame_n}, {31'd0, c != 0});
    end
    @(negedge clk);
    chk(lad_oe && lad_out == 4'hF, "R6 host tar", {27'd0, lad_oe, lad_out}, 32'h1F);
    @(negedge clk);
    chk(!lad_oe, "R6 float", {31'd0, lad_oe}, 32'd0);
    chk(!req_ready, "R2 busy", {31'd0, req_ready}, 32'd0);
    for (int w = 0; w < ((v.waits >= LIMIT) ? LIMIT : int'(v.waits)); w++) begin
      @(negedge clk);
      lad_in = 4'b0101;
      chk(!rsp_valid && !lad_oe, "R7 waiting", {30'd0, rsp_valid, lad_oe}, 32'd0);
    end
    if (v.waits < LIMIT) begin
      @(negedge clk);
      lad_in = v.fin;
      if (v.fin == 4'h0) begin
        if (!v.wr) begin
          @(negedge clk); lad_in = v.rdata[3:0];
          @(negedge clk); lad_in = v.rdata[7:4];
        end
        @(negedge clk); lad_in = 4'hF;
        chk(!rsp_valid && !lad_oe, "R9 target tar", {30'd0, rsp_valid, lad_oe}, 32'd0);
        @(negedge clk); lad_in = 4'hF;
      end
    end
    @(negedge clk);
    lad_in = 4'hF;
    if (hold) req_valid = 1'b0;
    exp_rd = (v.status == 2'd0 && !v.wr) ? v.rdata : 8'h00;
    tag = (v.status == 2'd1) ? "R10 timeout" : (v.status == 2'd2) ? "R11 bad sync" :
          v.wr ? "R9 write done" : "R8 read data";
    chk(rsp_valid && rsp_status == v.status && rsp_rdata == exp_rd, tag,
        {21'd0, rsp_valid, rsp_status, rsp_rdata}, {21'd0, 1'b1, v.status, exp_rd});
    @(negedge clk);
    chk(!rsp_valid, "R12 single pulse", {31'd0, rsp_valid}, 32'd0);
    chk(req_ready && frame_n && !lad_oe, "R9 idle again",
        {29'd0, req_ready, frame_n, lad_oe}, 32'h6);
  endtask

  initial begin
    #1;
    chk(req_ready && frame_n && !lad_oe && !rsp_valid, "R1 in reset",
        {28'd0, req_ready, frame_n, lad_oe, rsp_valid}, 32'hC);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && frame_n && !lad_oe && !rsp_valid, "R1 after reset",
        {28'd0, req_ready, frame_n, lad_oe, rsp_valid}, 32'hC);

    for (int k = 0; k < NV; k++) run_txn(VECS[k], 1'b0);

    // R2: requests held during a transfer must not disturb it
    run_txn(VECS[0], 1'b1);
    run_txn(VECS[5], 1'b1);

    // R1: reset mid-frame releases the bus
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_id = 4'h4; req_addr = 28'h2222222;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(lad_oe, "R4 mid-frame drive", {31'd0, lad_oe}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk(req_ready && frame_n && !lad_oe && !rsp_valid, "R1 async reset",
        {28'd0, req_ready, frame_n, lad_oe, rsp_valid}, 32'hC);
    @(negedge clk);
    rst_n = 1'b1;
    run_txn(VECS[2], 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule